// File: doc/BRIEF.md
# Snooping Invalidate-Based Cache Coherence Controller

This block is the coherence agent for one processor's private cache in a small symmetric multiprocessor built around a single shared bus. The cache is direct-mapped, and each line holds one data word. Every line carries one of three states:

- Invalid.
- Shared: a clean, read-only copy that may also exist in other caches.
- Exclusive: the only valid copy, writable and possibly newer than memory.

On the processor side the controller answers loads and stores. A load or store that cannot complete locally makes the controller request the bus. When it is granted, it issues a read, a read-for-ownership, an upgrade or a write-back.

On the snoop side the controller watches every transaction that another agent issues. It invalidates its own copy when another agent is about to write. When it holds the requested line Exclusive, it supplies the line's data instead of memory and lets memory capture that data.

The bus is atomic. An external round-robin arbiter grants one agent for exactly one cycle. In that cycle the granted agent drives the command and the address. All other agents snoop combinationally, and the memory or the owning cache returns the data. Every state change lands on the clock edge that closes the cycle. A processor holds its request until it sees a one-cycle response.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every line is Invalid (state code 0), `bus_req` is low and `cpu_resp_valid` is low.
- R2: A load that misses issues a bus read (command code 1), installs the word in Shared (state code 1) and returns the most recently written value of that address.
- R3: When another agent's bus read hits a line held Exclusive (state code 2), the holder raises `snoop_supply_o`, drives its word on `snoop_data_o` and drops to Shared; the word it supplies becomes memory's copy.
- R4: A store to a line held Shared issues an upgrade (command code 3); after it, the writer holds the line Exclusive and every other copy is Invalid.
- R5: A store to a line held Exclusive completes with no bus transaction, provided no other agent's transaction is in flight in that cycle; otherwise it waits a cycle.
- R6: A store miss issues a read-for-ownership (command code 2), takes the word from the Exclusive owner if there is one and otherwise from memory, leaves the line Exclusive, and invalidates every other copy.
- R7: A miss whose frame holds another address in Exclusive first issues a write-back (command code 4) carrying that address and word, then the miss transaction. A Shared occupant is replaced with no extra transaction.
- R8: The command is chosen in the grant cycle from the line's state at that moment. A store whose Shared copy was invalidated while it waited issues a read-for-ownership rather than an upgrade, so stores to one address take effect in the order they win the bus.
- R9: A load that hits a Shared or Exclusive line returns its word with no bus transaction.
- R10: `bus_req` stays high from the first request until the grant that completes the access and is low afterwards; `cpu_resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor access request, held until response |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load result (store data for stores) |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant; this agent owns the bus this cycle |
| bus_cmd_o | output | 3 | Command driven while granted, 0 otherwise |
| bus_addr_o | output | ADDR_W | Address driven while granted |
| bus_wdata_o | output | DATA_W | Write-back data driven while granted |
| bus_valid_i | input | 1 | A transaction is on the bus this cycle |
| bus_cmd_i | input | 3 | Command on the bus |
| bus_addr_i | input | ADDR_W | Address on the bus |
| bus_rdata_i | input | DATA_W | Data returned to the granted agent |
| snoop_supply_o | output | 1 | This agent supplies the data of the snooped transaction |
| snoop_shared_o | output | 1 | This agent holds a clean copy of the snooped address |
| snoop_data_o | output | DATA_W | Supplied data, zero when not supplying |
| probe_idx | input | IDX_W | Frame index to observe |
| probe_state | output | 2 | State code of the observed frame |
| probe_tag | output | TAG_W | Tag of the observed frame |

## Verification
The assertions assume the processor behaves in a fixed way. It keeps its request, direction, address and data steady from the cycle it raises the request until the response pulse, and it lowers the request in the cycle of that pulse.

They also assume the arbiter behaves in a fixed way. It grants at most one agent per cycle, grants only an agent that requests, and reflects the grant onto `bus_valid_i`. The other agents' snoop outputs are combined into `bus_rdata_i` within the same cycle.

The bench stays inside these assumptions. Its processor tasks drive requests on the falling edge and hold them until the response. Its round-robin arbiter grants a single requester combinationally. Its bus merges the supplier's data ahead of memory.

// File: rtl/coh_pkg.sv
// Package: shared encodings for the snooping coherence controller.
// Assumes: state and command codes are fixed and decoded by every agent on the bus.
package coh_pkg;

    // Line states; the codes are visible on probe_state.
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    // Bus commands; every agent decodes these codes while snooping.
    typedef enum logic [2:0] {
        BC_IDLE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPGR = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    // Processor-side sequencer states.
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_BUS  = 2'd1,
        PS_RESP = 2'd2
    } proc_st_e;

endpackage

// File: rtl/coh_line_array.sv
// Module: coh_line_array
// Holds state, tag and data of every direct-mapped frame.
// Three independent read ports serve the processor side, the snooper and the probe.
// One write port rewrites a whole frame.
// Assumes: the caller never needs two writes in one cycle.
module coh_line_array
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 6,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic [IDX_W-1:0]  c_idx,
    output line_st_e          c_state,
    output logic [TAG_W-1:0]  c_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_e          st_q   [NUM_LINES];
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES];

    // State storage: cleared to Invalid on reset, rewritten on a frame write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i] <= LS_INV;
            end
        end else if (wr_en) begin
            st_q[wr_idx] <= wr_state;
        end
    end

    // Tag and data storage: no reset needed, qualified by state.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Read ports: purely combinational lookups.
    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];
    assign c_state = st_q[c_idx];
    assign c_tag   = tag_q[c_idx];

endmodule

// File: rtl/coh_snoop.sv
// Module: coh_snoop
// Decides this agent's reaction to another agent's bus transaction.
// The reaction covers the next frame state, supplying data, and asserting the shared signal.
// Assumes: snoop_en is low whenever this agent itself holds the grant.
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              snoop_en,
    input  bus_cmd_e          cmd,
    input  logic [TAG_W-1:0]  bus_tag,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_st_e          upd_state,
    output logic              supply,
    output logic              shared,
    output logic [DATA_W-1:0] supply_data
);

    logic hit;

    // Match: a valid frame holding the snooped address.
    assign hit = snoop_en && (line_state != LS_INV) && (line_tag == bus_tag);

    // Reaction table for the three snooped commands that affect copies.
    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        supply    = 1'b0;
        shared    = 1'b0;
        if (hit) begin
            unique case (cmd)
                BC_RD: begin
                    if (line_state == LS_EXC) begin
                        supply    = 1'b1;
                        upd_en    = 1'b1;
                        upd_state = LS_SHR;
                    end else begin
                        shared = 1'b1;
                    end
                end
                BC_RDX: begin
                    supply    = (line_state == LS_EXC);
                    upd_en    = 1'b1;
                    upd_state = LS_INV;
                end
                BC_UPGR: begin
                    upd_en    = 1'b1;
                    upd_state = LS_INV;
                end
                default: begin
                end
            endcase
        end
    end

    // Supplied word, zero when idle so agents can be OR-merged.
    assign supply_data = supply ? line_data : '0;

endmodule

// File: rtl/coh_req_fsm.sv
// Module: coh_req_fsm
// Processor-side sequencer. It resolves hits locally and requests the bus on misses and upgrades.
// It picks the command in the grant cycle from the frame's current state.
// It produces the frame update for its own transactions.
// Assumes: the processor holds its request steady until the response pulse.
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  logic              bus_busy,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              upd_en,
    output line_st_e          upd_state,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [DATA_W-1:0] upd_data,
    output proc_st_e          fsm_state,
    output logic              wr_hit
);

    proc_st_e          ps_q;
    logic [DATA_W-1:0] rdata_q;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              tag_hit;
    logic              victim_dirty;
    logic              local_done;
    bus_cmd_e          cmd_sel;

    assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign req_idx = cpu_req_addr[IDX_W-1:0];

    // Hit detection against the frame the request indexes.
    assign tag_hit      = (line_state != LS_INV) && (line_tag == req_tag);
    assign wr_hit       = tag_hit && (line_state == LS_EXC);
    assign victim_dirty = (line_state == LS_EXC) && (line_tag != req_tag);

    // Local completion: load hit anytime, store hit only while the bus is quiet.
    assign local_done = cpu_req_valid &&
                        (cpu_req_write ? (wr_hit && !bus_busy) : tag_hit);

    // Command selection from the frame state seen in this cycle.
    always_comb begin
        if (victim_dirty)        cmd_sel = BC_WB;
        else if (!cpu_req_write) cmd_sel = BC_RD;
        else if (tag_hit)        cmd_sel = BC_UPGR;
        else                     cmd_sel = BC_RDX;
    end

    // Bus drive: only in the granted cycle.
    always_comb begin
        bus_req   = (ps_q == PS_BUS);
        bus_cmd   = BC_IDLE;
        bus_addr  = '0;
        bus_wdata = '0;
        if ((ps_q == PS_BUS) && bus_gnt) begin
            bus_cmd = cmd_sel;
            if (cmd_sel == BC_WB) begin
                bus_addr  = {line_tag, req_idx};
                bus_wdata = line_data;
            end else begin
                bus_addr = cpu_req_addr;
            end
        end
    end

    // Frame update for own transactions and for local store hits.
    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        upd_tag   = req_tag;
        upd_data  = cpu_req_wdata;
        if ((ps_q == PS_BUS) && bus_gnt) begin
            upd_en = 1'b1;
            unique case (cmd_sel)
                BC_WB: begin
                    upd_state = LS_INV;
                    upd_tag   = line_tag;
                    upd_data  = line_data;
                end
                BC_RD: begin
                    upd_state = LS_SHR;
                    upd_data  = bus_rdata;
                end
                default: upd_state = LS_EXC;
            endcase
        end else if ((ps_q == PS_IDLE) && local_done && cpu_req_write) begin
            upd_en    = 1'b1;
            upd_state = LS_EXC;
        end
    end

    // Sequencer: idle -> (bus) -> response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= PS_IDLE;
            rdata_q <= '0;
        end else begin
            unique case (ps_q)
                PS_IDLE: begin
                    if (local_done) begin
                        ps_q    <= PS_RESP;
                        rdata_q <= cpu_req_write ? cpu_req_wdata : line_data;
                    end else if (cpu_req_valid && !(cpu_req_write && wr_hit)) begin
                        ps_q <= PS_BUS;
                    end
                end
                PS_BUS: begin
                    if (bus_gnt && (cmd_sel != BC_WB)) begin
                        ps_q    <= PS_RESP;
                        rdata_q <= (cmd_sel == BC_RD) ? bus_rdata : cpu_req_wdata;
                    end
                end
                default: ps_q <= PS_IDLE;
            endcase
        end
    end

    assign cpu_resp_valid = (ps_q == PS_RESP);
    assign cpu_resp_rdata = rdata_q;
    assign fsm_state      = ps_q;

endmodule

// File: rtl/snoop_coh_ctrl.sv
// Module: snoop_coh_ctrl (top)
// Per-cache coherence controller joining the frame store, the processor-side sequencer and the snoop responder.
// Own transactions and snoop reactions never update the frame store in the same cycle.
// Assumes: the arbiter grants one agent per cycle and bus_valid_i mirrors that grant.
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 4,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_valid_i,
    input  logic [2:0]        bus_cmd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              snoop_supply_o,
    output logic              snoop_shared_o,
    output logic [DATA_W-1:0] snoop_data_o,
    input  logic [IDX_W-1:0]  probe_idx,
    output logic [1:0]        probe_state,
    output logic [TAG_W-1:0]  probe_tag
);

    line_st_e          own_state, snp_state, prb_state;
    logic [TAG_W-1:0]  own_tag, snp_tag;
    logic [DATA_W-1:0] own_data, snp_data;
    logic              f_upd_en, s_upd_en;
    line_st_e          f_upd_state, s_upd_state;
    logic [TAG_W-1:0]  f_upd_tag;
    logic [DATA_W-1:0] f_upd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    bus_cmd_e          f_cmd;
    proc_st_e          fsm_state;
    logic              wr_hit;
    logic              snoop_en;

    // Snoop only transactions issued by other agents.
    assign snoop_en = bus_valid_i && !bus_gnt;

    coh_line_array #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (cpu_req_addr[IDX_W-1:0]),
        .a_state  (own_state),
        .a_tag    (own_tag),
        .a_data   (own_data),
        .b_idx    (bus_addr_i[IDX_W-1:0]),
        .b_state  (snp_state),
        .b_tag    (snp_tag),
        .b_data   (snp_data),
        .c_idx    (probe_idx),
        .c_state  (prb_state),
        .c_tag    (probe_tag),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_state (wr_state),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    coh_req_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .line_state     (own_state),
        .line_tag       (own_tag),
        .line_data      (own_data),
        .bus_busy       (snoop_en),
        .bus_gnt        (bus_gnt),
        .bus_rdata      (bus_rdata_i),
        .bus_req        (bus_req),
        .bus_cmd        (f_cmd),
        .bus_addr       (bus_addr_o),
        .bus_wdata      (bus_wdata_o),
        .upd_en         (f_upd_en),
        .upd_state      (f_upd_state),
        .upd_tag        (f_upd_tag),
        .upd_data       (f_upd_data),
        .fsm_state      (fsm_state),
        .wr_hit         (wr_hit)
    );

    coh_snoop #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_snoop (
        .snoop_en    (snoop_en),
        .cmd         (bus_cmd_e'(bus_cmd_i)),
        .bus_tag     (bus_addr_i[ADDR_W-1:IDX_W]),
        .line_state  (snp_state),
        .line_tag    (snp_tag),
        .line_data   (snp_data),
        .upd_en      (s_upd_en),
        .upd_state   (s_upd_state),
        .supply      (snoop_supply_o),
        .shared      (snoop_shared_o),
        .supply_data (snoop_data_o)
    );

    // Frame write select: own activity first, snoop reaction otherwise.
    always_comb begin
        if (f_upd_en) begin
            wr_en    = 1'b1;
            wr_idx   = cpu_req_addr[IDX_W-1:0];
            wr_state = f_upd_state;
            wr_tag   = f_upd_tag;
            wr_data  = f_upd_data;
        end else begin
            wr_en    = s_upd_en;
            wr_idx   = bus_addr_i[IDX_W-1:0];
            wr_state = s_upd_state;
            wr_tag   = snp_tag;
            wr_data  = snp_data;
        end
    end

    assign bus_cmd_o   = f_cmd;
    assign probe_state = prb_state;

endmodule

// File: rtl/coh_ctrl_chk.sv
// Module: coh_ctrl_chk
// Temporal checks on one controller, attached by bind.
// Assumes: the processor and arbiter keep to the protocol stated in the brief.
module coh_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [2:0] bus_cmd_o,
    input logic       bus_valid_i,
    input logic       cpu_resp_valid,
    input logic       cpu_req_valid,
    input logic       cpu_req_write,
    input logic       snoop_supply_o,
    input logic [1:0] own_state,
    input logic [1:0] fsm_state,
    input logic       wr_hit
);

    // Request is held until a grant arrives.
    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);

    // Response is a single-cycle pulse.
    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid);

    // An agent never supplies data to its own transaction.
    assert_no_self_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !snoop_supply_o);

    // A bus read leaves the requester's frame Shared.
    assert_rd_installs_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt && bus_cmd_o == 3'd1 |=> own_state == 2'd1);

    // An upgrade leaves the writer Exclusive.
    assert_upgr_gives_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt && bus_cmd_o == 3'd3 |=> own_state == 2'd2);

    // A read-for-ownership leaves the writer Exclusive.
    assert_rdx_gives_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt && bus_cmd_o == 3'd2 |=> own_state == 2'd2);

    // A write-back frees the frame and the miss request stays up.
    assert_wb_frees_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt && bus_cmd_o == 3'd4 |=> own_state == 2'd0 && bus_req);

    // A store hit on Exclusive with a quiet bus never goes to the bus.
    assert_exc_hit_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 2'd0 && cpu_req_valid && cpu_req_write && wr_hit && !bus_valid_i
        |=> !bus_req);

endmodule

bind snoop_coh_ctrl coh_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .bus_cmd_o      (bus_cmd_o),
    .bus_valid_i    (bus_valid_i),
    .cpu_resp_valid (cpu_resp_valid),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_write  (cpu_req_write),
    .snoop_supply_o (snoop_supply_o),
    .own_state      (own_state),
    .fsm_state      (fsm_state),
    .wr_hit         (wr_hit)
);

// File: tb/sim_snoop_coh_ctrl.sv
// Bench: four controllers, a round-robin arbiter and a behavioural memory on one atomic bus.
module sim_snoop_coh_ctrl;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NC = 4;
    localparam logic [AW-1:0] AX = 8'h01;
    localparam logic [AW-1:0] AY = 8'h05;
    localparam logic [AW-1:0] AZ = 8'h02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          rq_v   [NC];
    logic          rq_w   [NC];
    logic [AW-1:0] rq_a   [NC];
    logic [DW-1:0] rq_d   [NC];
    logic          rs_v   [NC];
    logic [DW-1:0] rs_d   [NC];
    logic [NC-1:0] breq, gnt;
    logic [2:0]    c_cmd  [NC];
    logic [AW-1:0] c_addr [NC];
    logic [DW-1:0] c_wd   [NC];
    logic          c_sup  [NC];
    logic          c_shr  [NC];
    logic [DW-1:0] c_sd   [NC];
    logic [1:0]    p_st   [NC];
    logic [5:0]    p_tag  [NC];
    logic [1:0]    probe_idx;

    logic          b_valid, any_sup;
    logic [2:0]    b_cmd;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wd, b_sd, b_rdata;
    logic [1:0]    rr_ptr;
    logic [DW-1:0] mem [256];

    for (genvar i = 0; i < NC; i++) begin : g_cache
        snoop_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(4)) u0 (
            .clk(clk), .rst_n(rst_n),
            .cpu_req_valid(rq_v[i]), .cpu_req_write(rq_w[i]),
            .cpu_req_addr(rq_a[i]), .cpu_req_wdata(rq_d[i]),
            .cpu_resp_valid(rs_v[i]), .cpu_resp_rdata(rs_d[i]),
            .bus_req(breq[i]), .bus_gnt(gnt[i]),
            .bus_cmd_o(c_cmd[i]), .bus_addr_o(c_addr[i]), .bus_wdata_o(c_wd[i]),
            .bus_valid_i(b_valid), .bus_cmd_i(b_cmd), .bus_addr_i(b_addr),
            .bus_rdata_i(b_rdata),
            .snoop_supply_o(c_sup[i]), .snoop_shared_o(c_shr[i]), .snoop_data_o(c_sd[i]),
            .probe_idx(probe_idx), .probe_state(p_st[i]), .probe_tag(p_tag[i])
        );
    end

    // Round-robin grant, one requester per cycle.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt = '0;
        for (int k = 0; k < NC; k++) begin
            logic [1:0] c;
            c = rr_ptr + 2'(k);
            if (!found && breq[c]) begin
                gnt[c] = 1'b1;
                found = 1'b1;
            end
        end
    end

    // Bus merge: granted agent's drive, supplier data ahead of memory.
    always_comb begin
        b_cmd = '0; b_addr = '0; b_wd = '0; b_sd = '0; any_sup = 1'b0;
        for (int k = 0; k < NC; k++) begin
            b_cmd   = b_cmd | c_cmd[k];
            b_addr  = b_addr | c_addr[k];
            b_wd    = b_wd | c_wd[k];
            b_sd    = b_sd | c_sd[k];
            any_sup = any_sup | c_sup[k];
        end
        b_valid = |gnt;
        b_rdata = any_sup ? b_sd : mem[b_addr];
    end

    // Arbiter pointer and memory updates.
    always @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
            for (int a = 0; a < 256; a++) mem[a] <= 32'h5EED_0000 + 32'(a);
        end else if (b_valid) begin
            for (int k = 0; k < NC; k++) if (gnt[k]) rr_ptr <= 2'(k + 1);
            if (b_cmd == 3'd4) mem[b_addr] <= b_wd;
            else if (any_sup) mem[b_addr] <= b_sd;
        end
    end

    // Transaction log, sampled mid-cycle.
    int         n_txn;
    logic [2:0] t_cmd [8];
    int         t_who [8];
    logic       t_sup [8];
    always @(negedge clk) begin
        if (rst_n && b_valid && n_txn < 8) begin
            t_cmd[n_txn] = b_cmd;
            t_sup[n_txn] = any_sup;
            for (int k = 0; k < NC; k++) if (gnt[k]) t_who[n_txn] = k;
            n_txn = n_txn + 1;
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] refm [256];
    logic [DW-1:0] last_rd;

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One processor access, held until the response pulse.
    task automatic do_op(input int c, input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        @(negedge clk);
        n_txn = 0;
        rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = a; rq_d[c] = d;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (rs_v[c]) break;
        end
        check("R10", "response seen", 32'(rs_v[c]), 32'd1);
        last_rd = rs_d[c];
        rq_v[c] = 1'b0;
        if (wr) refm[a] = d;
    endtask

    // Trace step: access, then read value and bus commands.
    task automatic trace_op(input string rq, input int c, input logic wr,
                            input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int en, input logic [2:0] e0, input logic [2:0] e1);
        do_op(c, wr, a, d);
        if (!wr) check(rq, "read value", last_rd, refm[a]);
        check(rq, "bus transactions", 32'(n_txn), 32'(en));
        if (en > 0) check(rq, "first command", 32'(t_cmd[0]), 32'(e0));
        if (en > 1) check(rq, "second command", 32'(t_cmd[1]), 32'(e1));
    endtask

    // Frame states of all caches at one index; tags compared for valid frames only.
    task automatic chk_lines(input string rq, input logic [1:0] idx,
                             input logic [1:0] s0, input logic [5:0] g0,
                             input logic [1:0] s1, input logic [5:0] g1,
                             input logic [1:0] s2, input logic [5:0] g2,
                             input logic [1:0] s3, input logic [5:0] g3);
        logic [1:0] es [NC];
        logic [5:0] eg [NC];
        es[0] = s0; es[1] = s1; es[2] = s2; es[3] = s3;
        eg[0] = g0; eg[1] = g1; eg[2] = g2; eg[3] = g3;
        probe_idx = idx;
        #1;
        for (int k = 0; k < NC; k++) begin
            check(rq, $sformatf("cache %0d state", k), 32'(p_st[k]), 32'(es[k]));
            if (es[k] != 2'd0) check(rq, $sformatf("cache %0d tag", k), 32'(p_tag[k]), 32'(eg[k]));
        end
    endtask

    // Scenario: reset leaves everything Invalid and quiet (R1).
    task automatic t_reset();
        for (int i = 0; i < 4; i++) chk_lines("R1", 2'(i), 0, 0, 0, 0, 0, 0, 0, 0);
        check("R1", "no bus request", 32'(breq), 32'd0);
        for (int k = 0; k < NC; k++) check("R1", "no response", 32'(rs_v[k]), 32'd0);
    endtask

    // Scenario: thirteen-step sharing trace on two addresses of one frame.
    task automatic t_trace();
        trace_op("R2", 0, 0, AX, 0, 1, 1, 0);
        chk_lines("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
        trace_op("R2", 1, 0, AX, 0, 1, 1, 0);
        chk_lines("R2", 1, 1, 0, 1, 0, 0, 0, 0, 0);
        trace_op("R2", 2, 0, AX, 0, 1, 1, 0);
        chk_lines("R2", 1, 1, 0, 1, 0, 1, 0, 0, 0);
        trace_op("R4", 0, 1, AX, 32'hA0A0_0004, 1, 3, 0);
        chk_lines("R4", 1, 2, 0, 0, 0, 0, 0, 0, 0);
        trace_op("R5", 0, 1, AX, 32'hA0A0_0005, 0, 0, 0);
        chk_lines("R5", 1, 2, 0, 0, 0, 0, 0, 0, 0);
        trace_op("R6", 2, 1, AX, 32'hCCCC_0006, 1, 2, 0);
        check("R6", "owner supplied", 32'(t_sup[0]), 32'd1);
        chk_lines("R6", 1, 0, 0, 0, 0, 2, 0, 0, 0);
        trace_op("R3", 1, 0, AX, 0, 1, 1, 0);
        check("R3", "owner supplied", 32'(t_sup[0]), 32'd1);
        chk_lines("R3", 1, 0, 0, 1, 0, 1, 0, 0, 0);
        trace_op("R3", 0, 0, AX, 0, 1, 1, 0);
        check("R3", "memory took owner data", 32'(t_sup[0]), 32'd0);
        chk_lines("R3", 1, 1, 0, 1, 0, 1, 0, 0, 0);
        trace_op("R7", 0, 0, AY, 0, 1, 1, 0);
        chk_lines("R7", 1, 1, 1, 1, 0, 1, 0, 0, 0);
        trace_op("R4", 1, 1, AX, 32'hBBBB_0010, 1, 3, 0);
        chk_lines("R4", 1, 1, 1, 2, 0, 0, 0, 0, 0);
        trace_op("R7", 1, 0, AY, 0, 2, 4, 1);
        chk_lines("R7", 1, 1, 1, 1, 1, 0, 0, 0, 0);
        trace_op("R6", 1, 1, AX, 32'hBBBB_0012, 1, 2, 0);
        chk_lines("R6", 1, 1, 1, 2, 0, 0, 0, 0, 0);
        trace_op("R7", 1, 1, AY, 32'hBBBB_0013, 2, 4, 2);
        chk_lines("R7", 1, 0, 0, 2, 1, 0, 0, 0, 0);
    endtask

    // Scenario: written-back and owned values reach other readers; hits stay local.
    task automatic t_after();
        trace_op("R7", 2, 0, AX, 0, 1, 1, 0);
        trace_op("R3", 3, 0, AY, 0, 1, 1, 0);
        check("R3", "owner supplied", 32'(t_sup[0]), 32'd1);
        chk_lines("R3", 1, 0, 0, 1, 1, 1, 0, 1, 1);
        trace_op("R9", 1, 0, AY, 0, 0, 0, 0);
        trace_op("R9", 2, 0, AX, 0, 0, 0, 0);
    endtask

    // Scenario: two Shared holders store at once; the later winner must own the line.
    task automatic t_race();
        int win, lose, done0, done1;
        logic [DW-1:0] wd [2];
        trace_op("R2", 0, 0, AZ, 0, 1, 1, 0);
        trace_op("R2", 1, 0, AZ, 0, 1, 1, 0);
        wd[0] = 32'hAAAA_7000; wd[1] = 32'hBBBB_7000;
        @(negedge clk);
        n_txn = 0; done0 = 0; done1 = 0;
        for (int k = 0; k < 2; k++) begin
            rq_v[k] = 1'b1; rq_w[k] = 1'b1; rq_a[k] = AZ; rq_d[k] = wd[k];
        end
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (rs_v[0]) begin done0 = 1; rq_v[0] = 1'b0; end
            if (rs_v[1]) begin done1 = 1; rq_v[1] = 1'b0; end
            if (done0 == 1 && done1 == 1) break;
        end
        check("R8", "both stores done", 32'(done0 + done1), 32'd2);
        check("R8", "transactions", 32'(n_txn), 32'd2);
        win  = t_who[0];
        lose = 1 - win;
        check("R8", "first command", 32'(t_cmd[0]), 32'd3);
        check("R8", "second command", 32'(t_cmd[1]), 32'd2);
        check("R8", "second issuer", 32'(t_who[1]), 32'(lose));
        refm[AZ] = wd[lose];
        probe_idx = 2'd2;
        #1;
        check("R8", "earlier winner state", 32'(p_st[win]), 32'd0);
        check("R8", "later winner state", 32'(p_st[lose]), 32'd2);
        trace_op("R8", 2, 0, AZ, 0, 1, 1, 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        n_txn = 0;
        probe_idx = '0;
        for (int k = 0; k < NC; k++) begin
            rq_v[k] = 1'b0; rq_w[k] = 1'b0; rq_a[k] = '0; rq_d[k] = '0;
        end
        for (int a = 0; a < 256; a++) refm[a] = 32'h5EED_0000 + 32'(a);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trace();
        t_after();
        t_race();
        @(negedge clk);
        check("R10", "requests idle at end", 32'(breq), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule